// File: doc/BRIEF.md
# PLL Controller Register Block with Divided Clock Enables

This block is the control side of a phase-locked-loop clock unit. A 32-bit memory-mapped port holds the pre-divider, multiplier and post-divider settings of the loop. The block reports the resulting output-to-reference ratio as a numerator and denominator pair. The analog loop itself is not modelled. Its output reaches the block as a one-cycle strobe on a fast system clock, and the reference clock arrives the same way.

From these strobes the block makes one-cycle clock-enable pulses for several derived clocks:
- Up to nine system dividers run from the PLL strobe. Each has its own ratio and its own enable.
- A bypass divider runs straight from the reference strobe.
- An observation path picks one of several source strobes, divides it, and gates the result.
- An auxiliary gate passes the reference strobe through.

Every ratio field stores the division value minus one. A new ratio takes effect only after the current division period completes.

Top module: `pll_ctrl_core`

## Requirements
- R1: After reset, every mapped register reads zero, and no system-divider, observation or auxiliary enable pulses while strobes arrive.
- R2: The register offsets are as follows. Each register reads back only the bits listed for it; all other bits read zero.
  - Loop settings: multiplier at 0x110, pre-divider at 0x114, post-divider at 0x128, each in bits [4:0].
  - Bypass divider at 0x12C, bits [4:0].
  - Observation divider at 0x124, bits [4:0].
  - Observation source select at 0x104, bits [1:0].
  - Gate control at 0x148, bits [1:0].
  - System dividers 1 to 3 at 0x118, 0x11C and 0x120.
  - System dividers 4 to 9 at 0x160 to 0x174, in steps of 4.
  - Each system divider register holds a ratio in bits [4:0] and an enable in bit 15.
- R3: A read of any other offset returns zero, and a write to it changes no register.
- R4: pll_num equals multiplier+1, and pll_den equals (pre-divider+1)*(post-divider+1).
- R5: An enabled system divider with ratio field N pulses once every N+1 PLL strobes, on the (N+1)th strobe. A disabled divider never pulses, and disabling it clears its count.
- R6: A ratio written to a running divider is used only after that divider's current terminal count. Its first pulse under the new value therefore still comes at the old spacing.
- R7: The bypass divider counts reference strobes with its own ratio and ignores PLL strobes.
- R8: aux_en repeats ref_stb while gate bit 0 is set and stays low while it is clear.
- R9: The observation path works in three stages:
  - The select field picks bit obs_src[select].
  - The observation ratio divides that strobe.
  - Gate bit 1 passes the result; clearing the bit blocks the pulses and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; zero when not reading |
| pll_stb | input | 1 | One-cycle strobe per PLL output period |
| ref_stb | input | 1 | One-cycle strobe per reference period |
| obs_src | input | 2**OSEL_W (4) | Candidate observation source strobes |
| sys_en | output | NDIV (9) | System divider enable pulses |
| bp_en | output | 1 | Bypass divider enable pulse |
| obs_en | output | 1 | Observation enable pulse |
| aux_en | output | 1 | Auxiliary gated reference pulse |
| pll_num | output | RW+1 (6) | Ratio numerator |
| pll_den | output | 2*RW+2 (12) | Ratio denominator |

## Verification
The checker assumes that every strobe input is a qualifier for one clock cycle. Under that assumption, each derived pulse must coincide with a strobe on its own source. It also assumes that bus offsets are compared over the whole address, which lets it decode the unmapped space on its own.

The stimulus drives strobes for exactly one cycle each. It performs register writes only in cycles with no source strobe, so every ratio or gate change lands at a known count. It also restarts a divider by disabling it, or by resetting the block, before each measured run.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
   localparam logic [11:0] OFF_OSEL  = 12'h104;
   localparam logic [11:0] OFF_MUL   = 12'h110;
   localparam logic [11:0] OFF_PRE   = 12'h114;
   localparam logic [11:0] OFF_OSC   = 12'h124;
   localparam logic [11:0] OFF_POST  = 12'h128;
   localparam logic [11:0] OFF_BYP   = 12'h12C;
   localparam logic [11:0] OFF_GATE  = 12'h148;
   localparam logic [11:0] OFF_DLO   = 12'h118;
   localparam logic [11:0] OFF_DHI   = 12'h160;
   localparam int          DIV_EN_BIT = 15;
   localparam int          DLO_COUNT  = 3;

   // System divider offsets: the first group is contiguous, the rest start higher up
   function automatic logic [11:0] div_off(input int idx);
      if (idx < DLO_COUNT) return OFF_DLO + 12'(4 * idx);
      else                 return OFF_DHI + 12'(4 * (idx - DLO_COUNT));
   endfunction
endpackage

// File: rtl/pll_ratio_calc.sv
module pll_ratio_calc #(
   parameter int RW = 5
) (
   input  logic [RW-1:0]     pre_q,
   input  logic [RW-1:0]     mul_q,
   input  logic [RW-1:0]     post_q,
   output logic [RW:0]       num,
   output logic [2*RW+1:0]   den
);
   localparam int NW = RW + 1;
   logic [NW-1:0] pre_v, post_v;

   always_comb begin
      pre_v  = {1'b0, pre_q}  + NW'(1);
      post_v = {1'b0, post_q} + NW'(1);
      num    = {1'b0, mul_q}  + NW'(1);
      den    = (2*NW)'(pre_v) * (2*NW)'(post_v);
   end
endmodule

// File: rtl/pll_stb_div.sv
module pll_stb_div #(
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          src,
   input  logic [RW-1:0] ratio,
   output logic          stb
);
   logic [RW-1:0] cnt_q, rat_q, eff_rat;
   logic          live_q;

   // First enabled cycle uses the live field; afterwards the latched one
   assign eff_rat = live_q ? rat_q : ratio;
   assign stb     = en && src && (cnt_q == eff_rat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rat_q  <= '0;
         live_q <= 1'b0;
      end else if (!en) begin
         cnt_q  <= '0;
         live_q <= 1'b0;
      end else begin
         live_q <= 1'b1;
         if (!live_q) rat_q <= ratio;
         if (src) begin
            if (cnt_q == eff_rat) begin
               cnt_q <= '0;
               rat_q <= ratio;
            end else begin
               cnt_q <= cnt_q + RW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
   import pll_ctrl_pkg::*;
#(
   parameter int AW     = 12,
   parameter int RW     = 5,
   parameter int NDIV   = 9,
   parameter int OSEL_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_we,
   input  logic [AW-1:0]            bus_addr,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic [RW-1:0]            pre_q,
   output logic [RW-1:0]            mul_q,
   output logic [RW-1:0]            post_q,
   output logic [RW-1:0]            byp_q,
   output logic [RW-1:0]            osc_q,
   output logic [OSEL_W-1:0]        osel_q,
   output logic [1:0]               gate_q,
   output logic [NDIV-1:0][RW-1:0]  div_rat_q,
   output logic [NDIV-1:0]          div_en_q
);
   logic wr, rd;
   assign wr = bus_sel &&  bus_we;
   assign rd = bus_sel && !bus_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q     <= '0;
         mul_q     <= '0;
         post_q    <= '0;
         byp_q     <= '0;
         osc_q     <= '0;
         osel_q    <= '0;
         gate_q    <= '0;
         div_rat_q <= '0;
         div_en_q  <= '0;
      end else if (wr) begin
         if (bus_addr == AW'(OFF_PRE))  pre_q  <= bus_wdata[RW-1:0];
         if (bus_addr == AW'(OFF_MUL))  mul_q  <= bus_wdata[RW-1:0];
         if (bus_addr == AW'(OFF_POST)) post_q <= bus_wdata[RW-1:0];
         if (bus_addr == AW'(OFF_BYP))  byp_q  <= bus_wdata[RW-1:0];
         if (bus_addr == AW'(OFF_OSC))  osc_q  <= bus_wdata[RW-1:0];
         if (bus_addr == AW'(OFF_OSEL)) osel_q <= bus_wdata[OSEL_W-1:0];
         if (bus_addr == AW'(OFF_GATE)) gate_q <= bus_wdata[1:0];
         for (int i = 0; i < NDIV; i++) begin
            if (bus_addr == AW'(div_off(i))) begin
               div_rat_q[i] <= bus_wdata[RW-1:0];
               div_en_q[i]  <= bus_wdata[DIV_EN_BIT];
            end
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         if (bus_addr == AW'(OFF_PRE))  bus_rdata = 32'(pre_q);
         if (bus_addr == AW'(OFF_MUL))  bus_rdata = 32'(mul_q);
         if (bus_addr == AW'(OFF_POST)) bus_rdata = 32'(post_q);
         if (bus_addr == AW'(OFF_BYP))  bus_rdata = 32'(byp_q);
         if (bus_addr == AW'(OFF_OSC))  bus_rdata = 32'(osc_q);
         if (bus_addr == AW'(OFF_OSEL)) bus_rdata = 32'(osel_q);
         if (bus_addr == AW'(OFF_GATE)) bus_rdata = 32'(gate_q);
         for (int i = 0; i < NDIV; i++) begin
            if (bus_addr == AW'(div_off(i))) begin
               bus_rdata = 32'(div_rat_q[i]);
               bus_rdata[DIV_EN_BIT] = div_en_q[i];
            end
         end
      end
   end
endmodule

// File: rtl/pll_ctrl_core.sv
module pll_ctrl_core #(
   parameter int AW     = 12,
   parameter int RW     = 5,
   parameter int NDIV   = 9,
   parameter int OSEL_W = 2,
   localparam int NOBS  = 1 << OSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [AW-1:0]     bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              pll_stb,
   input  logic              ref_stb,
   input  logic [NOBS-1:0]   obs_src,
   output logic [NDIV-1:0]   sys_en,
   output logic              bp_en,
   output logic              obs_en,
   output logic              aux_en,
   output logic [RW:0]       pll_num,
   output logic [2*RW+1:0]   pll_den
);
   if (RW < 1 || RW > 15) begin : g_bad_rw
      $error("RW must lie in 1..15 so the enable bit stays clear of the ratio");
   end
   if (NDIV < 1 || NDIV > 9) begin : g_bad_ndiv
      $error("NDIV must lie in 1..9");
   end
   if (AW < 9) begin : g_bad_aw
      $error("AW too narrow for the register offsets");
   end
   if (OSEL_W < 1 || OSEL_W > 4) begin : g_bad_osel
      $error("OSEL_W must lie in 1..4");
   end

   logic [RW-1:0]            pre_q, mul_q, post_q, byp_q, osc_q;
   logic [OSEL_W-1:0]        osel_q;
   logic [1:0]               gate_q;
   logic [NDIV-1:0][RW-1:0]  div_rat_q;
   logic [NDIV-1:0]          div_en_q;
   logic                     obs_pick;

   pll_ctrl_regs #(.AW(AW), .RW(RW), .NDIV(NDIV), .OSEL_W(OSEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pre_q(pre_q), .mul_q(mul_q), .post_q(post_q), .byp_q(byp_q),
      .osc_q(osc_q), .osel_q(osel_q), .gate_q(gate_q),
      .div_rat_q(div_rat_q), .div_en_q(div_en_q)
   );

   pll_ratio_calc #(.RW(RW)) u_ratio (
      .pre_q(pre_q), .mul_q(mul_q), .post_q(post_q),
      .num(pll_num), .den(pll_den)
   );

   for (genvar g = 0; g < NDIV; g++) begin : g_sys
      pll_stb_div #(.RW(RW)) u_div (
         .clk(clk), .rst_n(rst_n), .en(div_en_q[g]), .src(pll_stb),
         .ratio(div_rat_q[g]), .stb(sys_en[g])
      );
   end

   pll_stb_div #(.RW(RW)) u_byp (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .src(ref_stb),
      .ratio(byp_q), .stb(bp_en)
   );

   assign obs_pick = obs_src[osel_q];

   // Gate bit 1 both blocks the observation output and restarts its count
   pll_stb_div #(.RW(RW)) u_obs (
      .clk(clk), .rst_n(rst_n), .en(gate_q[1]), .src(obs_pick),
      .ratio(osc_q), .stb(obs_en)
   );

   assign aux_en = ref_stb && gate_q[0];
endmodule

// File: rtl/pll_ctrl_chk.sv
module pll_ctrl_chk #(
   parameter int AW   = 12,
   parameter int RW   = 5,
   parameter int NDIV = 9,
   parameter int NOBS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [AW-1:0]     bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              pll_stb,
   input logic              ref_stb,
   input logic [NOBS-1:0]   obs_src,
   input logic [NDIV-1:0]   sys_en,
   input logic              bp_en,
   input logic              obs_en,
   input logic              aux_en,
   input logic [RW:0]       pll_num,
   input logic [2*RW+1:0]   pll_den
);
   function automatic logic known(input logic [AW-1:0] a);
      int v;
      v = int'(a);
      return (v == 'h104) || (v >= 'h110 && v <= 'h12C && v[1:0] == 2'b00)
          || (v == 'h148) || (v >= 'h160 && v <= 'h174 && v[1:0] == 2'b00);
   endfunction

   // R3: unmapped reads give zero
   a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && !known(bus_addr)) |-> (bus_rdata == 32'd0));

   // R5: system pulses only ride on PLL strobes
   a_r5_sys_on_pll: assert property (@(posedge clk) disable iff (!rst_n)
      (|sys_en) |-> pll_stb);

   // R7: bypass pulses only ride on reference strobes
   a_r7_byp_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
      bp_en |-> ref_stb);

   // R8: auxiliary pulses only ride on reference strobes
   a_r8_aux_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
      aux_en |-> ref_stb);

   // R9: observation pulses need some source strobe
   a_r9_obs_on_src: assert property (@(posedge clk) disable iff (!rst_n)
      obs_en |-> (|obs_src));

   // R4: ratio terms are never zero
   a_r4_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_num != '0) && (pll_den != '0));
endmodule

bind pll_ctrl_core pll_ctrl_chk #(.AW(AW), .RW(RW), .NDIV(NDIV), .NOBS(NOBS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pll_stb(pll_stb),
   .ref_stb(ref_stb), .obs_src(obs_src), .sys_en(sys_en), .bp_en(bp_en),
   .obs_en(obs_en), .aux_en(aux_en), .pll_num(pll_num), .pll_den(pll_den)
);

// File: tb/pll_ctrl_core_bench.sv
module pll_ctrl_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pll_stb = 1'b0, ref_stb = 1'b0;
   logic [3:0]  obs_src = '0;
   logic [8:0]  sys_en;
   logic        bp_en, obs_en, aux_en;
   logic [5:0]  pll_num;
   logic [11:0] pll_den;

   int checks = 0, errors = 0;
   int c_sys[9];
   int c_bp = 0, c_obs = 0, c_aux = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pll_ctrl_core u_pll_ctrl_core (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pll_stb(pll_stb), .ref_stb(ref_stb), .obs_src(obs_src),
      .sys_en(sys_en), .bp_en(bp_en), .obs_en(obs_en), .aux_en(aux_en),
      .pll_num(pll_num), .pll_den(pll_den)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 9; i++) if (sys_en[i]) c_sys[i]++;
         if (bp_en)  c_bp++;
         if (obs_en) c_obs++;
         if (aux_en) c_aux++;
      end
   end

   function automatic logic [11:0] doff(input int i);
      return (i < 3) ? 12'(32'h118 + 4*i) : 12'(32'h160 + 4*(i-3));
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #2 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 0;
   endtask

   task automatic clr();
      for (int i = 0; i < 9; i++) c_sys[i] = 0;
      c_bp = 0; c_obs = 0; c_aux = 0;
   endtask

   task automatic drive(input int n, input int gap, input bit p, input bit r, input logic [3:0] o);
      for (int k = 0; k < n*gap; k++) begin
         @(posedge clk); #1;
         if (k % gap == 0) begin pll_stb = p; ref_stb = r; obs_src = o; end
         else begin pll_stb = 0; ref_stb = 0; obs_src = 0; end
      end
      @(posedge clk); #1;
      pll_stb = 0; ref_stb = 0; obs_src = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
   endtask

   initial begin : watchdog
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      logic [11:0] maps[17];
      logic [31:0] masks[17];
      int s;
      for (int i = 0; i < 9; i++) c_sys[i] = 0;
      maps[0] = 12'h104; masks[0] = 32'h3;
      maps[1] = 12'h110; masks[1] = 32'h1F;
      maps[2] = 12'h114; masks[2] = 32'h1F;
      maps[3] = 12'h124; masks[3] = 32'h1F;
      maps[4] = 12'h128; masks[4] = 32'h1F;
      maps[5] = 12'h12C; masks[5] = 32'h1F;
      maps[6] = 12'h148; masks[6] = 32'h3;
      for (int i = 0; i < 9; i++) begin maps[7+i] = doff(i); masks[7+i] = 32'h801F; end
      maps[16] = 12'h118; masks[16] = 32'h801F;

      do_reset();
      // R1 reset state
      for (int i = 0; i < 17; i++) begin
         rd(maps[i], d);
         check($sformatf("R1 reset read 0x%0h", maps[i]), int'(d), 0);
      end
      clr();
      drive(8, 1, 1, 1, 4'hF);
      s = 0;
      for (int i = 0; i < 9; i++) s += c_sys[i];
      check("R1 no sys pulses after reset", s, 0);
      check("R1 no obs pulses after reset", c_obs, 0);
      check("R1 no aux pulses after reset", c_aux, 0);

      // R2 map and field masks
      for (int i = 0; i < 16; i++) begin
         wr(maps[i], 32'hFFFF_FFFF);
         rd(maps[i], d);
         check($sformatf("R2 mask at 0x%0h", maps[i]), int'(d), int'(masks[i]));
         wr(maps[i], 32'h0);
         rd(maps[i], d);
         check($sformatf("R2 clear at 0x%0h", maps[i]), int'(d), 0);
      end

      // R3 unmapped offsets
      wr(12'h160, 32'h8005);
      foreach (maps[i]) if (i < 0) d = 0;
      for (int k = 0; k < 5; k++) begin
         logic [11:0] a;
         a = (k == 0) ? 12'h108 : (k == 1) ? 12'h15C : (k == 2) ? 12'h178 :
             (k == 3) ? 12'h000 : 12'h162;
         wr(a, 32'hFFFF_FFFF);
         rd(a, d);
         check($sformatf("R3 unmapped read 0x%0h", a), int'(d), 0);
      end
      rd(12'h160, d);
      check("R3 neighbour untouched", int'(d), 32'h8005);
      for (int i = 0; i < 16; i++) begin
         if (maps[i] != 12'h160) begin
            rd(maps[i], d);
            check($sformatf("R3 register 0x%0h untouched", maps[i]), int'(d), 0);
         end
      end
      wr(12'h160, 32'h0);

      // R4 ratio
      wr(12'h114, 3); wr(12'h110, 19); wr(12'h128, 1);
      #1 check("R4 numerator", int'(pll_num), 20);
      check("R4 denominator", int'(pll_den), 8);
      wr(12'h114, 31); wr(12'h110, 31); wr(12'h128, 31);
      #1 check("R4 numerator max", int'(pll_num), 32);
      check("R4 denominator max", int'(pll_den), 1024);
      wr(12'h114, 0); wr(12'h110, 0); wr(12'h128, 4);
      #1 check("R4 numerator min", int'(pll_num), 1);
      check("R4 denominator post only", int'(pll_den), 5);

      // R5 sweep of every system divider
      for (int i = 0; i < 9; i++) begin
         for (int n = 0; n < 6; n++) begin
            wr(doff(i), 32'h8000 | 32'(n));
            clr();
            drive(60, 1, 1, 0, 4'h0);
            check($sformatf("R5 div%0d ratio%0d", i, n), c_sys[i], 60/(n+1));
            s = 0;
            for (int j = 0; j < 9; j++) if (j != i) s += c_sys[j];
            check($sformatf("R5 disabled quiet div%0d", i), s, 0);
            wr(doff(i), 32'h0);
         end
      end
      wr(doff(8), 32'h8002);
      clr();
      drive(30, 3, 1, 0, 4'h0);
      check("R5 sparse pll strobes", c_sys[8], 10);
      wr(doff(8), 32'h0);
      wr(doff(4), 32'h8004);
      clr();
      drive(4, 1, 1, 0, 4'h0);
      check("R5 no pulse before strobe N+1", c_sys[4], 0);
      drive(1, 1, 1, 0, 4'h0);
      check("R5 pulse on strobe N+1", c_sys[4], 1);
      wr(doff(4), 32'h0);
      drive(3, 1, 1, 0, 4'h0);
      wr(doff(4), 32'h8004);
      clr();
      drive(4, 1, 1, 0, 4'h0);
      check("R5 disable clears count", c_sys[4], 0);
      wr(doff(4), 32'h0);

      // R6 ratio change waits for terminal count
      wr(doff(0), 32'h8003);
      clr();
      drive(2, 1, 1, 0, 4'h0);
      wr(doff(0), 32'h8000);
      drive(1, 1, 1, 0, 4'h0);
      check("R6 old ratio still counting", c_sys[0], 0);
      drive(1, 1, 1, 0, 4'h0);
      check("R6 pulse at old terminal", c_sys[0], 1);
      drive(4, 1, 1, 0, 4'h0);
      check("R6 new ratio after terminal", c_sys[0], 5);
      wr(doff(0), 32'h0);

      // R7 bypass divider
      for (int n = 0; n < 6; n++) begin
         do_reset();
         wr(12'h12C, 32'(n));
         clr();
         drive(61, 1, 0, 1, 4'h0);
         check($sformatf("R7 bypass ratio%0d", n), c_bp, 1 + 60/(n+1));
      end
      clr();
      drive(20, 1, 1, 0, 4'h0);
      check("R7 bypass ignores pll strobes", c_bp, 0);

      // R8 auxiliary gate
      do_reset();
      wr(12'h148, 32'h1);
      clr();
      drive(10, 2, 0, 1, 4'h0);
      check("R8 aux follows ref", c_aux, 10);
      wr(12'h148, 32'h0);
      clr();
      drive(10, 1, 0, 1, 4'h0);
      check("R8 aux gated off", c_aux, 0);

      // R9 observation path
      for (int sel = 0; sel < 4; sel++) begin
         for (int n = 0; n < 3; n += 2) begin
            wr(12'h148, 32'h0);
            wr(12'h104, 32'(sel));
            wr(12'h124, 32'(n));
            wr(12'h148, 32'h2);
            clr();
            drive(60, 1, 0, 0, 4'(1 << sel));
            check($sformatf("R9 sel%0d ratio%0d", sel, n), c_obs, 60/(n+1));
            clr();
            drive(20, 1, 0, 0, 4'hF & ~4'(1 << sel));
            check($sformatf("R9 sel%0d other sources ignored", sel), c_obs, 0);
         end
      end
      wr(12'h148, 32'h0);
      clr();
      drive(20, 1, 0, 0, 4'hF);
      check("R9 gate bit 1 clear blocks obs", c_obs, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule